// File: doc/BRIEF.md
# Cascadable Four-Channel Periodic Down-Counter

This peripheral holds four independent 32-bit down-counters, each of which marks the end of its period with a sticky timeout flag. A per-channel interrupt line follows that flag when the channel's interrupt enable is on. Software reaches the block through a single-cycle synchronous register port. Writes are taken on the clock edge and reads are combinational from the address. One module-wide word can shut off all counting. The same word can also make the counters hold whenever the debug-halt input is high.

A channel runs from its load value down to zero. On the step after zero it reloads and raises its flag. A load value written part way through a period does not disturb the running count. Instead, it is picked up at the next reload. A channel with its cascade bit set does not advance on every clock. It takes one step only in a cycle in which the channel below it expires. This lets two or more channels form one long period. Channel 0 has nothing below it, so its cascade bit is stored but ignored.

Top module: `chain_tick_timer`

## Requirements
- R1: After reset the module word (byte offset 0x0) reads 0x6: bit 0 freeze = 0, bit 1 disable = 1, bit 2 always reads 1. Every channel register reads 0 and all interrupt lines are low. While disable is 1, no counter loads or changes.
- R2: Channel n occupies byte offsets 0x100+0x10*n (load), +0x4 (current value, read-only), +0x8 (control: bit 0 enable, bit 1 interrupt enable, bit 2 cascade) and +0xC (flag: bit 0 timeout). Only word-aligned addresses are decoded.
- R3: On the first running clock after a channel becomes enabled, its current value becomes the load value. On each later running clock it drops by one. On the clock after it reads zero it reloads and sets its flag, so a load value L gives a period of L+1 steps.
- R4: Writing the load register does not change the current value. The new value is used at the next reload.
- R5: Clearing the enable and setting it again starts a fresh period from the load value.
- R6: A cascaded channel n (n > 0) steps by one only in a cycle in which channel n-1 expires. The cascade bit of channel 0 has no effect on its counting.
- R7: Writing 1 to flag bit 0 clears the flag and writing 0 leaves it unchanged. If a timeout occurs in the same cycle as a clearing write, the flag stays 1.
- R8: The interrupt line of a channel is high exactly while both its flag and its interrupt enable are 1. Setting the interrupt enable while the flag is already set raises the line on the next cycle.
- R9: While freeze is 1 and debug-halt is high, all counters hold their values. Debug-halt with freeze at 0 has no effect.
- R10: A disabled channel's current value keeps the value it had when the channel was disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_addr | input | AW (12) | Byte address for read and write |
| bus_wdata | input | W (32) | Write data |
| bus_rdata | output | W (32) | Read data for bus_addr, combinational |
| dbg_halt | input | 1 | Debug-halt request |
| irq | output | NCH (4) | Per-channel interrupt lines |

## Verification
The sharpest collision is a counter's expiry falling in the same cycle as a software write of 1 to that channel's flag. In that cycle the set must win. The bench provokes it by issuing clearing writes on several back-to-back cycles against a short period, so at least one write is sure to land on an expiry. A behavioural model compares the flag, the interrupt lines and the addressed register on every clock. A second overlap is a load write landing on the reload cycle, where the old load value must still be the one taken.

// File: rtl/chain_tick_timer.sv
module chain_tick_timer #(
  parameter int NCH = 4,
  parameter int W   = 32,
  parameter int AW  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          dbg_halt,
  output logic [NCH-1:0] irq
);
  localparam int SW = AW - 4;

  logic frz, mdis;
  logic [W-1:0] ld  [NCH];
  logic [W-1:0] cnt [NCH];
  logic [NCH-1:0] en, ie, chn, flg, live, tick, expd;

  wire run = !mdis && !(frz && dbg_halt);
  wire aligned = bus_addr[1:0] == 2'b00;
  wire [SW-1:0] slot  = bus_addr[AW-1:4];
  wire [SW-1:0] chsel = slot - SW'(16);
  wire in_ch   = aligned && (slot >= SW'(16)) && (chsel < SW'(NCH));
  wire top_hit = bus_addr == '0;
  wire [1:0] sub = bus_addr[3:2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frz  <= 1'b0;
      mdis <= 1'b1;
    end else if (bus_wr && top_hit) begin
      frz  <= bus_wdata[0];
      mdis <= bus_wdata[1];
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire wsel = bus_wr && in_ch && (chsel == SW'(i));

    if (i == 0) begin : g_head
      assign tick[i] = run & en[i] & live[i];
    end else begin : g_link
      assign tick[i] = run & en[i] & live[i] & (~chn[i] | expd[i-1]);
    end
    assign expd[i] = tick[i] && (cnt[i] == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ld[i]   <= '0;
        cnt[i]  <= '0;
        en[i]   <= 1'b0;
        ie[i]   <= 1'b0;
        chn[i]  <= 1'b0;
        flg[i]  <= 1'b0;
        live[i] <= 1'b0;
      end else begin
        if (!en[i]) live[i] <= 1'b0;
        else if (run && !live[i]) begin
          live[i] <= 1'b1;
          cnt[i]  <= ld[i];
        end else if (expd[i]) cnt[i] <= ld[i];
        else if (tick[i])     cnt[i] <= cnt[i] - 1'b1;

        if (expd[i]) flg[i] <= 1'b1;
        else if (wsel && sub == 2'd3 && bus_wdata[0]) flg[i] <= 1'b0;

        if (wsel && sub == 2'd0) ld[i] <= bus_wdata;
        if (wsel && sub == 2'd2) begin
          en[i]  <= bus_wdata[0];
          ie[i]  <= bus_wdata[1];
          chn[i] <= bus_wdata[2];
        end
      end
    end
  end

  assign irq = flg & ie;

  always_comb begin
    bus_rdata = '0;
    if (top_hit) bus_rdata[2:0] = {1'b1, mdis, frz};
    for (int i = 0; i < NCH; i++) begin
      if (in_ch && chsel == SW'(i)) begin
        case (sub)
          2'd0: bus_rdata = ld[i];
          2'd1: bus_rdata = cnt[i];
          2'd2: bus_rdata[2:0] = {chn[i], ie[i], en[i]};
          default: bus_rdata[0] = flg[i];
        endcase
      end
    end
  end
endmodule

module chain_tick_timer_chk #(
  parameter int NCH = 4,
  parameter int W   = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic           mdis,
  input logic           frz,
  input logic           dbg_halt,
  input logic [NCH-1:0] flg,
  input logic [NCH-1:0] ie,
  input logic [NCH-1:0] irq,
  input logic [W-1:0]   cnt0,
  input logic [W-1:0]   cnt1
);
  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg[0] && !bus_wr) |=> flg[0]);
  // R1
  disable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mdis |=> ($stable(cnt0) && $stable(cnt1)));
  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz && dbg_halt) |=> ($stable(cnt0) && $stable(cnt1)));
  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq[0]) |-> (flg[0] && ie[0]));
  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flg[1]) |-> !irq[1]);
endmodule

bind chain_tick_timer chain_tick_timer_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .mdis(mdis), .frz(frz),
  .dbg_halt(dbg_halt), .flg(flg), .ie(ie), .irq(irq),
  .cnt0(cnt[0]), .cnt1(cnt[1])
);

// File: tb/chain_tick_timer_tb.sv
module chain_tick_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic dbg_halt = 1'b0;
  logic [3:0] irq;

  always #5 clk = ~clk;

  chain_tick_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dbg_halt(dbg_halt), .irq(irq)
  );

  // behavioural reference
  logic [31:0] m_ld [4];
  logic [31:0] m_cnt [4];
  bit m_en [4], m_ie [4], m_ch [4], m_fl [4], m_lv [4];
  bit m_frz, m_dis;

  always @(posedge clk) begin
    bit run;
    bit tk [4];
    bit ex [4];
    int a;
    int c;
    int r;
    if (!rst_n) begin
      m_frz = 0; m_dis = 1;
      for (int i = 0; i < 4; i++) begin
        m_ld[i] = 0; m_cnt[i] = 0; m_en[i] = 0; m_ie[i] = 0;
        m_ch[i] = 0; m_fl[i] = 0; m_lv[i] = 0;
      end
    end else begin
      run = !m_dis && !(m_frz && dbg_halt);
      for (int i = 0; i < 4; i++) begin
        tk[i] = run && m_en[i] && m_lv[i] && (i == 0 || !m_ch[i] || ex[i-1]);
        ex[i] = tk[i] && m_cnt[i] == 0;
      end
      a = int'(bus_addr);
      c = -1; r = 0;
      if (bus_wr && a >= 'h100 && a < 'h140 && a % 4 == 0) begin
        c = (a - 'h100) / 16; r = (a / 4) % 4;
      end
      for (int i = 0; i < 4; i++) begin
        if (!m_en[i]) m_lv[i] = 0;
        else if (run && !m_lv[i]) begin m_lv[i] = 1; m_cnt[i] = m_ld[i]; end
        else if (ex[i]) m_cnt[i] = m_ld[i];
        else if (tk[i]) m_cnt[i] = m_cnt[i] - 1;
        if (ex[i]) m_fl[i] = 1;
        else if (c == i && r == 3 && bus_wdata[0]) m_fl[i] = 0;
        if (c == i && r == 0) m_ld[i] = bus_wdata;
        if (c == i && r == 2) begin
          m_en[i] = bus_wdata[0]; m_ie[i] = bus_wdata[1]; m_ch[i] = bus_wdata[2];
        end
      end
      if (bus_wr && a == 0) begin m_frz = bus_wdata[0]; m_dis = bus_wdata[1]; end
    end
  end

  function automatic logic [31:0] model_read(input int a);
    int c;
    if (a == 0) return {29'd0, 1'b1, m_dis, m_frz};
    if (a < 'h100 || a >= 'h140 || a % 4 != 0) return 0;
    c = (a - 'h100) / 16;
    case ((a / 4) % 4)
      0: return m_ld[c];
      1: return m_cnt[c];
      2: return {29'd0, m_ch[c], m_ie[c], m_en[c]};
      default: return {31'd0, m_fl[c]};
    endcase
  endfunction

  int vectors = 0;
  int miscompares = 0;
  string tag = "R1";
  bit done = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s addr=0x%0h actual=0x%0h expected=0x%0h", req, bus_addr, act, exp);
    end
  endtask

  task automatic cyc();
    logic [3:0] ei;
    @(negedge clk);
    for (int i = 0; i < 4; i++) ei[i] = m_fl[i] & m_ie[i];
    check(bus_rdata, model_read(int'(bus_addr)), tag);
    check({28'd0, irq}, {28'd0, ei}, {tag, "/R8 irq"});
  endtask

  task automatic idle(input logic [11:0] a, input int n);
    bus_addr = a;
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    cyc();
    bus_wr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values, written out by hand
    @(negedge clk);
    bus_addr = 12'h000; #1 check(bus_rdata, 32'h6, "R1 module word");
    bus_addr = 12'h108; #1 check(bus_rdata, 32'h0, "R1 control");
    bus_addr = 12'h134; #1 check(bus_rdata, 32'h0, "R1 current");
    check({28'd0, irq}, 32'h0, "R1 irq");
    tag = "R1";
    wr(12'h100, 32'd5);
    wr(12'h108, 32'd1);
    idle(12'h104, 6);
    bus_addr = 12'h104; #1 check(bus_rdata, 32'h0, "R1 counter held while disabled");
    tag = "R3";
    wr(12'h000, 32'd0);
    idle(12'h104, 3);
    // R3: enable edge, one load clock, then 2 decrements
    bus_addr = 12'h104; #1 check(bus_rdata, 32'd3, "R3 count after start");
    idle(12'h10C, 16);
    tag = "R2";
    wr(12'h138, 32'h6);
    idle(12'h138, 2);
    idle(12'h13A, 1);
    tag = "R4";
    wr(12'h100, 32'd2);
    idle(12'h104, 14);
    tag = "R5";
    wr(12'h108, 32'd0);
    idle(12'h104, 3);
    wr(12'h100, 32'd4);
    wr(12'h108, 32'd1);
    idle(12'h104, 12);
    tag = "R7";
    wr(12'h100, 32'd2);
    idle(12'h10C, 6);
    wr(12'h10C, 32'd0);
    idle(12'h10C, 2);
    for (int k = 0; k < 8; k++) wr(12'h10C, 32'd1);
    idle(12'h10C, 4);
    tag = "R8";
    wr(12'h108, 32'd3);
    idle(12'h10C, 3);
    wr(12'h10C, 32'd1);
    idle(12'h10C, 5);
    tag = "R6";
    wr(12'h110, 32'd2);
    wr(12'h118, 32'd7);
    idle(12'h114, 30);
    wr(12'h120, 32'd1);
    wr(12'h128, 32'd7);
    idle(12'h124, 25);
    wr(12'h108, 32'd7);
    idle(12'h104, 10);
    tag = "R9";
    wr(12'h000, 32'd1);
    dbg_halt = 1;
    idle(12'h114, 10);
    idle(12'h104, 4);
    dbg_halt = 0;
    idle(12'h104, 4);
    wr(12'h000, 32'd0);
    dbg_halt = 1;
    idle(12'h104, 6);
    dbg_halt = 0;
    wr(12'h000, 32'd2);
    idle(12'h104, 6);
    wr(12'h000, 32'd0);
    tag = "R10";
    idle(12'h114, 5);
    wr(12'h118, 32'd0);
    idle(12'h114, 10);
    wr(12'h118, 32'd3);
    idle(12'h11C, 20);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule